// File: doc/BRIEF.md
# Clocked Serial Shift Interface

This block is the synchronous serial port of a small 4-bit controller. It moves one byte per transfer through an 8-bit shift register. The CPU bus sees that register as two 4-bit nibbles, and a 3-bit counter tracks how many bits have gone by. The serial clock is either made inside the block from a prescaler tick or taken from the clock pin. Data leaves on the falling edge and is captured on the rising edge, least significant bit first.

Software writes a 4-bit control word. The word chooses whether the clock pin is a plain port bit or the serial clock, whether the clock is internal or external, and the internal clock rate. Every write to the control word also re-initializes the unit. A start strobe arms the unit, and the unit then waits for the first falling clock edge before it transfers. The interrupt flag rises when a transfer completes and also when a transfer is aborted. There is one exception: an abort that lands in the first low phase of the clock does not raise the flag. A write to the neighbouring port-mode register while the unit is armed or shifting parks the unit until the control word is written again.

Top module: `ser_shift_unit`

## Requirements
- R1: After reset the control word is 0, the flag is low, `sck_o` is 1, `sck_oe` is 0, `sdo` is 1 and the data register is 0.
- R2: `wr_lo` loads `bus_wdata` into data bits 3:0 and `wr_hi` loads it into bits 7:4. The two halves are visible on `nib_lo` and `nib_hi`.
- R3: A start in idle arms the unit. The first falling clock edge begins the transfer. Each falling edge drives data bit 0 onto `sdo`. Each rising edge shifts the register right by one and puts `sdi` into bit 7.
- R4: The eighth rising edge ends the transfer, returns the unit to idle and sets the flag. The data register then holds the received byte.
- R5: The flag stays set until `irq_clr` is pulsed.
- R6: A control-word write during a transfer stops the transfer, clears the bit counter and sets the flag. The next transfer needs a full eight clocks.
- R7: Leaving the transfer during its first low clock phase leaves the flag unchanged. This holds for a control-word write and for a start. A start during a transfer re-arms the unit from bit 0, and after the first rising edge such a start sets the flag.
- R8: A new control word takes effect two cycles after its write. A start one cycle after the write still runs with the previous word.
- R9: The control word is coded as follows. Bit 0 = 1 makes the pin the serial clock. Bit 1 = 1 selects the internal clock. Bits 3:2 = r set the internal half period to 2^r prescaler ticks. `sck_oe` is 1 only when bits 1:0 are both 1. The internal clock rests high while idle.
- R10: A port-mode write while the unit is armed or transferring parks the unit. In that state starts and clock edges are ignored and the flag is not set, until the next control-word write. A port-mode write in idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wdata | input | 4 | Write data for control word and nibbles |
| wr_mode | input | 1 | Control-word write strobe |
| wr_lo | input | 1 | Lower data nibble write strobe |
| wr_hi | input | 1 | Upper data nibble write strobe |
| wr_pmode | input | 1 | Port-mode register write strobe |
| start | input | 1 | Start strobe |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| pre_tick | input | 1 | Prescaler tick, one cycle wide |
| sck_i | input | 1 | Clock pin input |
| sdi | input | 1 | Serial data in |
| sck_o | output | 1 | Clock pin output level |
| sck_oe | output | 1 | Clock pin drive enable |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Transfer end or abort flag |
| nib_lo | output | 4 | Data register bits 3:0 |
| nib_hi | output | 4 | Data register bits 7:4 |

## Verification
The bench aborts a transfer at two points: inside the first low clock phase and after some bits have moved. A design that ignores the first-low exception would raise a spurious flag. A design that keeps the bit counter across an abort would finish the next transfer after fewer than eight clocks. A start issued one cycle after a control-word write must still run on the external clock. Applying new settings at once would turn the pin driver on too early. A port-mode write while armed must freeze the unit, so that eight later clocks change neither the data nor the flag. The internal divider is checked by timing the first falling edge at a half period of four ticks.

// File: rtl/ser_shift_unit.sv
module ser_shift_unit #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4,
  parameter int DIV_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] bus_wdata,
  input  logic             wr_mode,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_pmode,
  input  logic             start,
  input  logic             irq_clr,
  input  logic             pre_tick,
  input  logic             sck_i,
  input  logic             sdi,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             sdo,
  output logic             irq,
  output logic [NIB_W-1:0] nib_lo,
  output logic [NIB_W-1:0] nib_hi
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_HOLD} st_t;

  st_t              st;
  logic [3:0]       mode_reg, mode_eff, run_mode;
  logic [CNT_W-1:0] bcnt;
  logic [DATA_W-1:0] shreg;
  logic [DIV_W-1:0] div, half_last;
  logic             first_low, sck_lvl, sck_prev, sdo_r, irq_r;
  logic             running, int_clk, tgl, fall_ev, rise_ev;
  logic             park, quiet, fall_go, fall_x, shift_en, done, abort_irq, clk_rst;

  assign running   = (st == S_WAIT) || (st == S_XFER);
  assign int_clk   = run_mode[1];
  assign half_last = DIV_W'((32'd1 << run_mode[3:2]) - 32'd1);
  assign tgl       = running && int_clk && pre_tick && (div == half_last);
  assign fall_ev   = int_clk ? (tgl && sck_lvl)  : (sck_prev && !sck_i);
  assign rise_ev   = int_clk ? (tgl && !sck_lvl) : (!sck_prev && sck_i);

  assign park      = wr_pmode && running;
  assign quiet     = !wr_mode && !park && !start;
  assign fall_go   = (st == S_WAIT) && fall_ev && quiet;
  assign fall_x    = (st == S_XFER) && fall_ev && quiet;
  assign shift_en  = (st == S_XFER) && rise_ev && quiet;
  assign done      = shift_en && (bcnt == LAST);
  assign abort_irq = (st == S_XFER) && !first_low && (wr_mode || (start && !wr_pmode));
  assign clk_rst   = wr_mode || park || ((st == S_XFER) && start) || !running;

  assign sck_oe = run_mode[0] && run_mode[1];
  assign sck_o  = sck_lvl;
  assign sdo    = sdo_r;
  assign irq    = irq_r;
  assign nib_lo = shreg[NIB_W-1:0];
  assign nib_hi = shreg[DATA_W-1:NIB_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_reg <= '0;
      mode_eff <= '0;
      run_mode <= '0;
      sck_prev <= 1'b1;
    end else begin
      if (wr_mode) mode_reg <= bus_wdata[3:0];
      mode_eff <= mode_reg;
      if (st == S_IDLE) run_mode <= mode_eff;
      sck_prev <= sck_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bcnt      <= '0;
      first_low <= 1'b0;
    end else if (wr_mode) begin
      st        <= S_IDLE;
      bcnt      <= '0;
      first_low <= 1'b0;
    end else if (park) begin
      st        <= S_HOLD;
      bcnt      <= '0;
      first_low <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) st <= S_WAIT;
        S_WAIT: if (fall_go) begin
          st        <= S_XFER;
          first_low <= 1'b1;
        end
        S_XFER: if (start) begin
          st        <= S_WAIT;
          bcnt      <= '0;
          first_low <= 1'b0;
        end else if (shift_en) begin
          first_low <= 1'b0;
          bcnt      <= done ? '0 : bcnt + 1'b1;
          if (done) st <= S_IDLE;
        end
        default: st <= S_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      sck_lvl <= 1'b1;
    end else if (clk_rst) begin
      div     <= '0;
      sck_lvl <= 1'b1;
    end else if (int_clk && pre_tick) begin
      if (div == half_last) begin
        div     <= '0;
        sck_lvl <= !sck_lvl;
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sdo_r <= 1'b1;
      irq_r <= 1'b0;
    end else begin
      if (wr_lo || wr_hi) begin
        if (wr_lo) shreg[NIB_W-1:0]      <= bus_wdata;
        if (wr_hi) shreg[DATA_W-1:NIB_W] <= bus_wdata;
      end else if (shift_en) begin
        shreg <= {sdi, shreg[DATA_W-1:1]};
      end
      if (fall_go || fall_x) sdo_r <= shreg[0];
      if (done || abort_irq) irq_r <= 1'b1;
      else if (irq_clr)      irq_r <= 1'b0;
    end
  end

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_r && !irq_clr) |=> irq_r);
  assert_abort_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && !first_low && wr_mode) |=> irq_r);
  assert_cnt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_XFER) |-> (bcnt == '0));
  assert_first_low_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && first_low && (wr_mode || start) && !irq_r) |=> !irq_r);
  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> sck_lvl);
  assert_park_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !wr_mode) |=> (st == S_HOLD && !$rose(irq_r)));
endmodule

// File: tb/test_ser_shift_unit.sv
`timescale 1ns/1ps
module test_ser_shift_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_wdata = '0;
  logic wr_mode = 0, wr_lo = 0, wr_hi = 0, wr_pmode = 0, start = 0, irq_clr = 0;
  logic pre_tick = 0, sck_i = 1, sdi_drv = 0, loop_en = 0;
  logic sdi, sck_o, sck_oe, sdo, irq;
  logic [3:0] nib_lo, nib_hi;
  int checks = 0, errors = 0;

  assign sdi = loop_en ? sdo : sdi_drv;
  always #2 clk = ~clk;

  ser_shift_unit i_ser_shift_unit (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_mode(wr_mode),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_pmode(wr_pmode), .start(start),
    .irq_clr(irq_clr), .pre_tick(pre_tick), .sck_i(sck_i), .sdi(sdi),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .irq(irq),
    .nib_lo(nib_lo), .nib_hi(nib_hi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wmode(input logic [3:0] v);
    wr_mode = 1; bus_wdata = v; cyc(); wr_mode = 0;
  endtask

  task automatic wdata(input logic [7:0] v);
    wr_lo = 1; bus_wdata = v[3:0]; cyc(); wr_lo = 0;
    wr_hi = 1; bus_wdata = v[7:4]; cyc(); wr_hi = 0;
  endtask

  task automatic go();
    start = 1; cyc(); start = 0;
  endtask

  task automatic clr();
    irq_clr = 1; cyc(); irq_clr = 0;
  endtask

  task automatic ext_bit(input logic din, output logic dout);
    sck_i = 0; cyc(); dout = sdo; sdi_drv = din; sck_i = 1; cyc();
  endtask

  task automatic ext_bits(input logic [7:0] din, input int n, output logic [7:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      logic b;
      ext_bit(din[i], b);
      dout[i] = b;
    end
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0); chk("R1 sck_o", sck_o, 1); chk("R1 sck_oe", sck_oe, 0);
    chk("R1 sdo", sdo, 1); chk("R1 data", {nib_hi, nib_lo}, 8'h00);
  endtask

  task automatic t_nibbles();
    wr_lo = 1; bus_wdata = 4'h7; cyc(); wr_lo = 0;
    chk("R2 lo", {nib_hi, nib_lo}, 8'h07);
    wr_hi = 1; bus_wdata = 4'hC; cyc(); wr_hi = 0;
    chk("R2 hi", {nib_hi, nib_lo}, 8'hC7);
  endtask

  task automatic t_ext_xfer();
    logic [7:0] got;
    wdata(8'h3C); go();
    chk("R3 armed no flag", irq, 0);
    ext_bits(8'h96, 8, got);
    chk("R3 sdo LSB first", got, 8'h3C);
    chk("R4 flag", irq, 1);
    chk("R4 rx byte", {nib_hi, nib_lo}, 8'h96);
    cyc(3);
    chk("R5 flag held", irq, 1);
    clr();
    chk("R5 cleared", irq, 0);
  endtask

  task automatic t_abort_mid();
    logic [7:0] got;
    wdata(8'h11); go(); ext_bits(8'h00, 3, got);
    wmode(4'h0);
    chk("R6 abort flag", irq, 1);
    clr(); cyc(2);
    go(); ext_bits(8'hFF, 7, got);
    chk("R6 no early end", irq, 0);
    ext_bits(8'h01, 1, got);
    chk("R6 full eight", irq, 1);
    clr();
  endtask

  task automatic t_first_low();
    logic [7:0] got;
    go(); sck_i = 0; cyc();
    wmode(4'h0); sck_i = 1; cyc();
    chk("R7 mode write in first low", irq, 0);
    cyc(2);
    go(); sck_i = 0; cyc();
    go();
    chk("R7 start in first low", irq, 0);
    sck_i = 1; cyc();
    ext_bits(8'h5A, 8, got);
    chk("R7 restart from bit 0", irq, 1);
    chk("R7 restart data", {nib_hi, nib_lo}, 8'h5A);
    clr();
    go(); ext_bits(8'h00, 2, got); go();
    chk("R7 start after first rise", irq, 1);
    clr(); wmode(4'h0); cyc(2);
  endtask

  task automatic t_latency_internal();
    pre_tick = 1;
    wmode(4'h3); go(); cyc(4);
    chk("R8 old word: no drive", sck_oe, 0);
    chk("R8 old word: no clock", sck_o, 1);
    wmode(4'h3);
    chk("R8 abort armed no flag", irq, 0);
    cyc(2);
    chk("R9 drive enabled", sck_oe, 1);
    wdata(8'hA5); loop_en = 1; go();
    for (int i = 0; i < 40 && !irq; i++) cyc();
    chk("R9 internal done", irq, 1);
    chk("R9 loopback data", {nib_hi, nib_lo}, 8'hA5);
    chk("R9 idle high", sck_o, 1);
    loop_en = 0; clr();
    wmode(4'hB); cyc(3);
    go(); cyc(3);
    chk("R9 high before half period", sck_o, 1);
    cyc();
    chk("R9 fall at 4 ticks", sck_o, 0);
    wmode(4'h0);
    chk("R7 internal first low", irq, 0);
    pre_tick = 0; cyc(3);
    chk("R9 back to external", sck_oe, 0);
  endtask

  task automatic t_park();
    logic [7:0] got;
    wdata(8'h5A); go();
    wr_pmode = 1; cyc(); wr_pmode = 0;
    go(); ext_bits(8'hFF, 8, got);
    chk("R10 parked no flag", irq, 0);
    chk("R10 parked data kept", {nib_hi, nib_lo}, 8'h5A);
    wmode(4'h0); cyc(2);
    wr_pmode = 1; cyc(); wr_pmode = 0;
    go(); ext_bits(8'hC3, 8, got);
    chk("R10 idle port write harmless", irq, 1);
    chk("R10 data after", {nib_hi, nib_lo}, 8'hC3);
    clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc();
    t_reset();
    t_nibbles();
    t_ext_xfer();
    t_abort_mid();
    t_first_low();
    t_latency_internal();
    t_park();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule